// File: doc/BRIEF.md
# CMOS Index and Data Port Unit with NMI Gate

This block sits on an 8-bit I/O bus and gives access to a 256-byte CMOS RAM held inside it. Four byte ports in a four-byte window starting at parameter `BASE` (70h by default) make up two access pairs. The legacy pair is at offsets 0 and 1: an index port that cannot be read and a data port. The alternate pair is at offsets 2 and 3: a readable index port and a data port. Both index ports write the same index register, so low index bits written through one pair are seen by the other.

The legacy index port also carries an NMI disable flag in bit 7. While that flag is set, rising edges on the two error sources (channel check and system error) do not reach the processor NMI line. The flag is always visible on a status output. The legacy data port can only reach the lower half of the RAM. The alternate data port reaches all of it.

Read data appears on `io_rdata` one clock after the read strobe and holds until the next read inside the window. The bus never asserts `io_rd` and `io_wr` in the same cycle.

Top module: `rtc_cmos_port`

## Requirements
- R1: During and after synchronous reset, `nmi_block` is 1, `nmi_out` is 0, `io_rdata` is 00h, and the 8-bit index reads back as 00h through offset 2.
- R2: A read at offset 0 puts FFh on `io_rdata` in the next cycle. After any read inside the window, `io_rdata` holds its value until the next read inside the window.
- R3: A write at offset 0 loads data bit 7 into `nmi_block` and data bits 6:0 into index bits 6:0, and clears index bit 7.
- R4: A write at offset 2 loads all 8 data bits into the index and leaves `nmi_block` unchanged.
- R5: A read at offset 2 returns the 8-bit index. After an offset 0 write this is {0, bits 6:0 written}. After an offset 2 write it is the full byte written.
- R6: Reads and writes at offset 1 access RAM byte {0, index[6:0]}, so index bit 7 has no effect and only bytes 00h to 7Fh are reachable.
- R7: Reads and writes at offset 3 access the RAM byte at the full 8-bit index.
- R8: `nmi_out` is high for exactly one cycle, the cycle after a clock at which (channel check OR system error) is 1, was 0 at the previous clock, and `nmi_block` is 0.
- R9: While `nmi_block` is 1, no NMI pulse is produced. A source that rose while blocked and is still high when the block is cleared produces no pulse.
- R10: Reads and writes whose address is outside the four-byte window change neither `io_rdata`, the index, `nmi_block` nor the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | W | Write data |
| io_rdata | output | W | Read data, valid the cycle after `io_rd` |
| err_iochk | input | 1 | Channel check error source |
| err_serr | input | 1 | System error source |
| nmi_out | output | 1 | One-cycle NMI request pulse |
| nmi_block | output | 1 | Current NMI disable flag |

## Verification
Index writes through both ports are interleaved with data accesses through both ports. A byte stored through offset 3 at an index with bit 7 set, then read back through offset 1, shows whether the legacy window truly drops index bit 7. Reading offset 2 after each kind of index write shows whether the readback depends on which port was written last. For the NMI path, the bench raises the error sources while blocked, clears the block while a source is held high, and applies clean and overlapping rising edges on both sources. This separates true edge detection from level detection and from gating that is applied late. A long pseudo-random mix of accesses inside and outside the window, with the error inputs toggling, is compared against the reference model on every clock.

// File: rtl/rtc_cmos_pkg.sv
package rtc_cmos_pkg;

  // Byte offset inside the four-byte window; the order is fixed by the bus map.
  typedef enum logic [1:0] {
    PORT_LIDX = 2'd0,  // legacy index + NMI disable
    PORT_LDAT = 2'd1,  // legacy data, lower half only
    PORT_AIDX = 2'd2,  // alternate index, readable
    PORT_ADAT = 2'd3   // alternate data, full range
  } port_e;

  localparam logic [7:0] LIDX_READ_VALUE = 8'hFF;

endpackage

// File: rtl/rtc_io_decode.sv
module rtc_io_decode
  import rtc_cmos_pkg::*;
#(
  parameter int unsigned          ADDR_W = 16,
  parameter logic [ADDR_W-1:0]    BASE   = 'h70
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output port_e             port
);
  always_comb begin
    hit  = (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    port = port_e'(addr[1:0]);
  end
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_legacy,
  input  logic         wr_alt,
  input  logic [W-1:0] wdata,
  output logic         nmi_dis,
  output logic [W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_dis <= 1'b1;
      idx     <= '0;
    end else if (wr_legacy) begin
      nmi_dis <= wdata[W-1];
      idx     <= {1'b0, wdata[W-2:0]};
    end else if (wr_alt) begin
      idx     <= wdata;
    end
  end
endmodule

// File: rtl/rtc_cmos_ram.sv
module rtc_cmos_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/rtc_nmi_gate.sv
module rtc_nmi_gate (
  input  logic clk,
  input  logic rst,
  input  logic src_a,
  input  logic src_b,
  input  logic block,
  output logic pulse
);
  logic src, src_q;

  assign src = src_a | src_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      pulse <= 1'b0;
    end else begin
      src_q <= src;
      pulse <= src & ~src_q & ~block;
    end
  end
endmodule

// File: rtl/rtc_cmos_port.sv
module rtc_cmos_port
  import rtc_cmos_pkg::*;
#(
  parameter int unsigned       W      = 8,
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 'h70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [W-1:0]      io_wdata,
  output logic [W-1:0]      io_rdata,
  input  logic              err_iochk,
  input  logic              err_serr,
  output logic              nmi_out,
  output logic              nmi_block
);
  logic         hit;
  port_e        port;
  logic [W-1:0] idx;
  logic [W-1:0] ram_addr;
  logic [W-1:0] ram_q;
  logic [W-1:0] reg_q;
  logic         from_ram;
  logic         is_data, ram_we, ram_re;

  rtc_io_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) dec_i (
    .addr(io_addr), .hit(hit), .port(port)
  );

  rtc_index_regs #(.W(W)) idx_i (
    .clk(clk), .rst(rst),
    .wr_legacy(hit && io_wr && port == PORT_LIDX),
    .wr_alt   (hit && io_wr && port == PORT_AIDX),
    .wdata(io_wdata), .nmi_dis(nmi_block), .idx(idx)
  );

  always_comb begin
    is_data  = (port == PORT_LDAT) || (port == PORT_ADAT);
    ram_we   = hit && io_wr && is_data;
    ram_re   = hit && io_rd && is_data;
    ram_addr = (port == PORT_LDAT) ? {1'b0, idx[W-2:0]} : idx;
  end

  rtc_cmos_ram #(.AW(W), .DW(W)) ram_i (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(io_wdata), .rdata(ram_q)
  );

  // Register-side read capture; data-side capture lives in the RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      from_ram <= 1'b0;
      reg_q    <= '0;
    end else if (hit && io_rd) begin
      from_ram <= is_data;
      if (port == PORT_LIDX) reg_q <= W'(LIDX_READ_VALUE);
      else if (port == PORT_AIDX) reg_q <= idx;
    end
  end

  assign io_rdata = from_ram ? ram_q : reg_q;

  rtc_nmi_gate nmi_i (
    .clk(clk), .rst(rst), .src_a(err_iochk), .src_b(err_serr),
    .block(nmi_block), .pulse(nmi_out)
  );
endmodule

// File: rtl/rtc_cmos_port_chk.sv
module rtc_cmos_port_chk #(
  parameter int unsigned       W      = 8,
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 'h70
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [W-1:0]      io_wdata,
  input logic [W-1:0]      io_rdata,
  input logic              err_iochk,
  input logic              err_serr,
  input logic              nmi_out,
  input logic              nmi_block
);
  logic in_win, wr_lidx, wr_aidx, rd_lidx;
  assign in_win  = io_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2];
  assign wr_lidx = in_win && io_wr && io_addr[1:0] == 2'd0;
  assign wr_aidx = in_win && io_wr && io_addr[1:0] == 2'd2;
  assign rd_lidx = in_win && io_rd && io_addr[1:0] == 2'd0;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> nmi_block && !nmi_out);
  // R2
  lidx_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    rd_lidx |=> io_rdata == {W{1'b1}});
  // R3
  lidx_sets_block_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lidx |=> nmi_block == $past(io_wdata[W-1]));
  // R4
  aidx_keeps_block_chk: assert property (@(posedge clk) disable iff (rst)
    wr_aidx |=> $stable(nmi_block));
  // R8
  nmi_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_out |-> $past(err_iochk || err_serr));
  // R8
  nmi_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_out |=> !nmi_out);
  // R9
  nmi_gated_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_out |-> !$past(nmi_block));
endmodule

bind rtc_cmos_port rtc_cmos_port_chk #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) chk_i (.*);

// File: tb/rtc_cmos_port_tb_top.sv
module rtc_cmos_port_tb_top;
  localparam int W = 8;
  localparam int ADDR_W = 16;
  localparam logic [15:0] BASE = 16'h0070;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] io_addr = '0;
  logic              io_rd = 1'b0, io_wr = 1'b0;
  logic [W-1:0]      io_wdata = '0;
  logic [W-1:0]      io_rdata;
  logic              err_iochk = 1'b0, err_serr = 1'b0;
  logic              nmi_out, nmi_block;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_cmos_port #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) dut_i (.*);

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [256];
  bit         m_dis = 1'b1;
  logic [7:0] m_idx = 8'h00;
  bit         m_prev = 1'b0;
  bit         e_nmi = 1'b0;
  logic [7:0] e_rdata = 8'h00;
  string      rd_tag = "R1";
  string      blk_tag = "R1";
  bit         e_blocked = 1'b0;
  bit         started = 1'b0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_dis = 1'b1; m_idx = 8'h00; m_prev = 1'b0; e_nmi = 1'b0;
      e_rdata = 8'h00; rd_tag = "R1"; blk_tag = "R1";
    end else begin
      int off;
      bit inwin, src;
      src = err_iochk | err_serr;
      e_blocked = src && !m_prev && m_dis;
      e_nmi = src && !m_prev && !m_dis;
      m_prev = src;
      inwin = (io_addr >> 2) == (BASE >> 2);
      off = int'(io_addr & 16'h3);
      if (io_rd && !inwin) rd_tag = "R10";
      if (io_wr && !inwin) blk_tag = "R10";
      if (io_rd && inwin) begin
        case (off)
          0: begin e_rdata = 8'hFF; rd_tag = "R2"; end
          1: begin e_rdata = m_mem[m_idx % 128]; rd_tag = "R6"; end
          2: begin e_rdata = m_idx; rd_tag = "R5"; end
          default: begin e_rdata = m_mem[m_idx]; rd_tag = "R7"; end
        endcase
      end
      if (io_wr && inwin) begin
        case (off)
          0: begin m_dis = io_wdata[7]; m_idx = io_wdata % 128; blk_tag = "R3"; end
          1: m_mem[m_idx % 128] = io_wdata;
          2: begin m_idx = io_wdata; blk_tag = "R4"; end
          default: m_mem[m_idx] = io_wdata;
        endcase
      end
    end
  end

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      check8(e_nmi ? "R8" : (e_blocked ? "R9" : "R8"), {7'b0, nmi_out}, {7'b0, e_nmi});
      check8(blk_tag, {7'b0, nmi_block}, {7'b0, m_dis});
      check8(rd_tag, io_rdata, e_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic errs(bit a, bit b);
    @(negedge clk);
    err_iochk = a; err_serr = b;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    idle(4);
    @(negedge clk) rst = 1'b0;
    // R1: reset state seen at the ports
    check8("R1", {7'b0, nmi_block}, 8'h01);
    check8("R1", {7'b0, nmi_out}, 8'h00);
    check8("R1", io_rdata, 8'h00);
    bus_rd(16'h0072);                 // R1/R5 index reads 00h
    check8("R1", io_rdata, 8'h00);

    // R3, R6: legacy pair, enabling NMI
    bus_wr(16'h0070, 8'h05);
    bus_wr(16'h0071, 8'hA5);
    bus_rd(16'h0071);
    check8("R6", io_rdata, 8'hA5);

    // R4, R7, R5: alternate pair with index bit 7 set
    bus_wr(16'h0072, 8'h85);
    bus_wr(16'h0073, 8'h3C);
    bus_rd(16'h0072);
    check8("R5", io_rdata, 8'h85);
    check8("R4", {7'b0, nmi_block}, 8'h00);
    bus_rd(16'h0073);
    check8("R7", io_rdata, 8'h3C);
    bus_rd(16'h0071);                 // R6: bit 7 dropped -> byte 05h
    check8("R6", io_rdata, 8'hA5);

    // R3, R5, R2: legacy write clears index bit 7 and sets block
    bus_wr(16'h0070, 8'h85);
    bus_rd(16'h0072);
    check8("R5", io_rdata, 8'h05);
    check8("R3", {7'b0, nmi_block}, 8'h01);
    bus_rd(16'h0070);
    check8("R2", io_rdata, 8'hFF);
    idle(3);
    check8("R2", io_rdata, 8'hFF);    // held
    bus_rd(16'h0073);
    check8("R7", io_rdata, 8'hA5);

    // Fill the whole RAM through the alternate pair (R7)
    for (int i = 0; i < 256; i++) begin
      bus_wr(16'h0072, 8'(i));
      bus_wr(16'h0073, 8'(i) ^ 8'h5A);
    end
    bus_wr(16'h0072, 8'hC3);
    bus_rd(16'h0073);
    check8("R7", io_rdata, 8'hC3 ^ 8'h5A);
    bus_rd(16'h0071);
    check8("R6", io_rdata, 8'h43 ^ 8'h5A);

    // R9: edges while blocked, unblock while held high
    errs(1, 0); idle(3);
    check8("R9", {7'b0, nmi_out}, 8'h00);
    bus_wr(16'h0070, 8'h10);
    idle(3);
    check8("R9", {7'b0, nmi_out}, 8'h00);
    errs(0, 0); idle(2);
    // R8: clean edge on system error
    errs(0, 1);
    @(negedge clk);
    check8("R8", {7'b0, nmi_out}, 8'h01);
    @(negedge clk);
    check8("R8", {7'b0, nmi_out}, 8'h00);
    errs(1, 1); idle(2);              // overlap: no new edge
    errs(1, 0); idle(2);
    errs(0, 0); errs(1, 0); idle(2);

    // R10: accesses outside the window
    bus_rd(16'h0070);
    bus_wr(16'h0074, 8'h77);
    bus_wr(16'h0170, 8'h80);
    bus_wr(16'h0172, 8'h01);
    bus_rd(16'h0075);
    check8("R10", io_rdata, 8'hFF);
    check8("R10", {7'b0, nmi_block}, 8'h00);
    bus_rd(16'h0072);
    check8("R10", io_rdata, 8'h10);

    // Pseudo-random mix, checked every clock by the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      io_addr  = lfsr[9] ? {14'h001C, lfsr[1:0]} : {13'h0, lfsr[4:2], 1'b0, lfsr[1:0]} + 16'h0060;
      io_wdata = lfsr[15:8];
      io_wr    = lfsr[5] & lfsr[6];
      io_rd    = ~io_wr & lfsr[7];
      err_iochk = lfsr[11] & lfsr[3];
      err_serr  = lfsr[14] & lfsr[2];
    end
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; err_iochk = 1'b0; err_serr = 1'b0;
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule